// File: doc/BRIEF.md
# Split Divide-by-Two / Divide-by-Five Decade Counter

This block is a four-bit decade counter made of two sections with separate advance inputs. The low section is a single toggling stage that divides by two. The high section is three stages that cycle through five states. A designer can run the two sections as independent dividers. Alternatively, the low bit can drive the high section, which makes a BCD counter that runs from 0 to 9 and wraps.

The model is fully synchronous. Each section has a one-cycle strobe that takes the place of a falling-edge clock input. In chained mode, the high section advances in the same cycle that the low bit drops from 1 to 0.

Two clear inputs force the count to zero, but only when both are high. Two set inputs force the count to nine, but only when both are high. Either forcing condition takes effect at the output at once, without waiting for a clock edge. It holds for as long as its inputs stay high, and the set condition wins when both conditions are active.

Top module: `split_decade_counter`

## Requirements
- R1: While rst_ni is low, count_o reads 4'b0000, and it remains 4'b0000 after release until a strobe arrives.
- R2: When no forcing condition is active, each clock cycle with tick_a_i high inverts count_o[0]. A cycle with tick_a_i low leaves count_o[0] unchanged.
- R3: With chain_i low, each cycle with tick_b_i high advances count_o[3:1], read as an unsigned number with bit 3 most significant, through 0,1,2,3,4 and back to 0. count_o[3:1] never reads 5, 6 or 7.
- R4: With chain_i low, the two sections are independent. tick_a_i never moves count_o[3:1], and tick_b_i never moves count_o[0].
- R5: With chain_i high, count_o[3:1] advances in exactly those cycles where tick_a_i takes count_o[0] from 1 to 0. count_o therefore steps through BCD 0 to 9, and the count after 9 is 0.
- R6: With chain_i high, tick_b_i has no effect on the count.
- R7: When clr_i equals 2'b11 and set_i is not 2'b11, count_o reads 4'b0000 in the same cycle, before any clock edge, and stays there while the condition holds. If only one clr_i bit is high, there is no effect.
- R8: When set_i equals 2'b11, count_o reads 4'b1001 in the same cycle and stays there while the condition holds. If only one set_i bit is high, there is no effect.
- R9: When clr_i and set_i both equal 2'b11, count_o reads 4'b1001.
- R10: After a forcing condition is released, counting resumes from the forced value. In chained mode, one tick_a_i after a set gives 4'b0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| chain_i | input | 1 | 1: low bit drives the high section (BCD) |
| tick_a_i | input | 1 | Advance strobe for the divide-by-two section |
| tick_b_i | input | 1 | Advance strobe for the divide-by-five section (chain_i low) |
| clr_i | input | 2 | Gated clear-to-zero pair |
| set_i | input | 2 | Gated set-to-nine pair |
| count_o | output | 4 | Count; bit 0 is the low section, bits 3:1 the high section |

## Verification
The stored state is visible at count_o directly, so a wrong internal state shows up in the next sample after the edge that caused it. The most likely faults each have a clear signature. A wrong wrap point in the high section shows as a value 5 to 7 on count_o[3:1]. A wrong chaining edge shows as the BCD sequence jumping on the rising edge of bit 0 instead of the falling edge. A forcing path that is registered rather than immediate shows a stale value in the cycle where clr_i or set_i is raised. A forced value that is not loaded into the registers shows as a wrong count one strobe after release.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  // width holding 0..mod-1
  function automatic int cnt_width(input int mod);
    return (mod <= 2) ? 1 : $clog2(mod);
  endfunction
endpackage

// File: rtl/sdc_force_decode.sv
module sdc_force_decode #(
  parameter int N_GATE = 2
) (
  input  logic [N_GATE-1:0] clr_i,
  input  logic [N_GATE-1:0] set_i,
  output logic              force_set_o,
  output logic              force_clr_o
);
  assign force_set_o = &set_i;
  assign force_clr_o = (&clr_i) & ~force_set_o; // set wins
endmodule

// File: rtl/sdc_div2_stage.sv
module sdc_div2_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic force_set_i,
  input  logic force_clr_i,
  output logic q_o,
  output logic fall_o
);
  logic q_r;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          q_r <= 1'b0;
    else if (force_set_i) q_r <= 1'b1;
    else if (force_clr_i) q_r <= 1'b0;
    else if (tick_i)      q_r <= ~q_r;
  end

  assign q_o    = force_set_i ? 1'b1 : (force_clr_i ? 1'b0 : q_r);
  assign fall_o = tick_i & q_r & ~force_set_i & ~force_clr_i;
endmodule

// File: rtl/sdc_divn_stage.sv
module sdc_divn_stage #(
  parameter int MOD = 5,
  localparam int W = sdc_pkg::cnt_width(MOD)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  input  logic         force_set_i,
  input  logic         force_clr_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] TOP_VAL = W'(MOD - 1);

  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;

  always_comb begin
    if (q_r >= TOP_VAL) q_nxt = '0;
    else                q_nxt = q_r + W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          q_r <= '0;
    else if (force_set_i) q_r <= TOP_VAL;
    else if (force_clr_i) q_r <= '0;
    else if (adv_i)       q_r <= q_nxt;
  end

  assign q_o = force_set_i ? TOP_VAL : (force_clr_i ? '0 : q_r);
endmodule

// File: rtl/split_decade_counter.sv
module split_decade_counter #(
  parameter int STAGE_B_MOD = 5,
  parameter int N_GATE      = 2,
  localparam int B_W   = sdc_pkg::cnt_width(STAGE_B_MOD),
  localparam int OUT_W = B_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              chain_i,
  input  logic              tick_a_i,
  input  logic              tick_b_i,
  input  logic [N_GATE-1:0] clr_i,
  input  logic [N_GATE-1:0] set_i,
  output logic [OUT_W-1:0]  count_o
);
  logic           force_set, force_clr;
  logic           q_a, fall_a, adv_b;
  logic [B_W-1:0] q_b;

  sdc_force_decode #(.N_GATE(N_GATE)) u_dec (
    .clr_i       (clr_i),
    .set_i       (set_i),
    .force_set_o (force_set),
    .force_clr_o (force_clr)
  );

  sdc_div2_stage u_sec_a (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_a_i),
    .force_set_i (force_set),
    .force_clr_i (force_clr),
    .q_o         (q_a),
    .fall_o      (fall_a)
  );

  // chained: high section steps on the low bit's 1->0 transition
  assign adv_b = chain_i ? fall_a : tick_b_i;

  sdc_divn_stage #(.MOD(STAGE_B_MOD)) u_sec_b (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .adv_i       (adv_b),
    .force_set_i (force_set),
    .force_clr_i (force_clr),
    .q_o         (q_b)
  );

  assign count_o = {q_b, q_a};
endmodule

// File: rtl/sdc_checker.sv
module sdc_checker #(
  parameter int STAGE_B_MOD = 5,
  parameter int N_GATE      = 2,
  localparam int B_W   = sdc_pkg::cnt_width(STAGE_B_MOD),
  localparam int OUT_W = B_W + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              chain_i,
  input logic              tick_a_i,
  input logic              tick_b_i,
  input logic [N_GATE-1:0] clr_i,
  input logic [N_GATE-1:0] set_i,
  input logic [OUT_W-1:0]  count_o
);
  localparam logic [B_W-1:0] B_TOP = B_W'(STAGE_B_MOD - 1);
  logic chk_set, chk_clr, chk_any;
  assign chk_set = &set_i;
  assign chk_clr = &clr_i;
  assign chk_any = chk_set | chk_clr;

  assert_set_nine_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_set |-> count_o == {B_TOP, 1'b1});

  assert_clr_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_clr && !chk_set) |-> count_o == '0);

  assert_hold_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_a_i && !chk_any) |=> (chk_any || count_o[0] == $past(count_o[0])));

  assert_high_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o[OUT_W-1:1] <= B_TOP);

  assert_bcd_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chain_i && tick_a_i && !chk_any && count_o == {B_TOP, 1'b1})
      |=> (chk_any || count_o == '0));
endmodule

bind split_decade_counter sdc_checker #(
  .STAGE_B_MOD(STAGE_B_MOD),
  .N_GATE     (N_GATE)
) u_chk (.*);

// File: tb/tb_split_decade_counter.sv
module tb_split_decade_counter;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       chain_i = 1'b0;
  logic       tick_a_i = 1'b0;
  logic       tick_b_i = 1'b0;
  logic [1:0] clr_i = 2'b00;
  logic [1:0] set_i = 2'b00;
  logic [3:0] count_o;

  split_decade_counter dut (.*);

  always #10 clk_i = ~clk_i; // 50 MHz

  typedef struct {
    logic [3:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  int ma = 0;
  int mb = 0;

  task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: count_o=%b expected %b", tag, act, exp);
    end
  endtask

  // driver: drive one cycle of stimulus and push the expected post-edge count
  task automatic step(input logic ta, input logic tb, input logic ch,
                      input logic [1:0] cl, input logic [1:0] st, input string tag);
    bit fall;
    @(negedge clk_i);
    tick_a_i = ta; tick_b_i = tb; chain_i = ch; clr_i = cl; set_i = st;
    if (st == 2'b11) begin
      ma = 1; mb = 4;
    end else if (cl == 2'b11) begin
      ma = 0; mb = 0;
    end else begin
      fall = ta && (ma == 1);
      if (ta) ma = 1 - ma;
      if (ch ? fall : tb) mb = (mb + 1) % 5;
    end
    q.push_back('{exp: 4'((mb << 1) | ma), tag: tag});
  endtask

  // forcing visible before the edge
  task automatic force_now(input logic [1:0] cl, input logic [1:0] st,
                           input logic [3:0] exp, input string tag);
    @(negedge clk_i);
    tick_a_i = 1'b0; tick_b_i = 1'b0; clr_i = cl; set_i = st;
    #2 check(count_o, exp, tag);
    ma = exp[0]; mb = int'(exp[3:1]);
    q.push_back('{exp: exp, tag: tag});
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk_i);
      #5;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        check(count_o, it.exp, it.tag);
      end
    end
  end

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: count_o=%b expected run to finish", count_o);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #35 check(count_o, 4'b0000, "R1 in reset");
    @(negedge clk_i); rst_ni = 1'b1;
    step(0, 0, 0, 2'b00, 2'b00, "R1 after release");

    // section A alone (R2), B untouched (R4)
    step(1, 0, 0, 2'b00, 2'b00, "R2 toggle");
    step(1, 0, 0, 2'b00, 2'b00, "R2 toggle back");
    step(1, 0, 0, 2'b00, 2'b00, "R4 tick_a leaves high section");
    step(0, 0, 0, 2'b00, 2'b00, "R2 hold");
    step(0, 0, 0, 2'b00, 2'b00, "R2 hold");

    // section B alone (R3), A untouched (R4)
    for (int i = 0; i < 6; i++) step(0, 1, 0, 2'b00, 2'b00, "R3 mod5 step");
    step(0, 0, 0, 2'b00, 2'b00, "R4 tick_b leaves low bit");
    step(1, 1, 0, 2'b00, 2'b00, "R4 both independent");
    for (int i = 0; i < 4; i++) step(0, 1, 0, 2'b00, 2'b00, "R3 wrap");

    // clear to zero, immediate (R7)
    force_now(2'b11, 2'b00, 4'b0000, "R7 immediate clear");
    step(1, 1, 0, 2'b11, 2'b00, "R7 clear holds");
    step(0, 0, 1, 2'b00, 2'b00, "R7 release");

    // BCD chain (R5), tick_b ignored (R6)
    for (int i = 0; i < 12; i++) step(1, 0, 1, 2'b00, 2'b00, "R5 bcd count");
    step(0, 1, 1, 2'b00, 2'b00, "R6 tick_b ignored");
    step(0, 1, 1, 2'b00, 2'b00, "R6 tick_b ignored");
    for (int i = 0; i < 9; i++) step(1, i[0], 1, 2'b00, 2'b00, "R5 bcd to wrap");

    // partial gates (R7, R8)
    step(1, 0, 1, 2'b10, 2'b00, "R7 one clr bit no effect");
    step(1, 0, 1, 2'b01, 2'b00, "R7 other clr bit no effect");
    step(1, 0, 1, 2'b00, 2'b01, "R8 one set bit no effect");
    step(1, 0, 1, 2'b00, 2'b10, "R8 other set bit no effect");

    // set to nine (R8), priority (R9), resume (R10)
    force_now(2'b00, 2'b11, 4'b1001, "R8 immediate set");
    step(1, 1, 1, 2'b00, 2'b11, "R8 set holds");
    force_now(2'b11, 2'b11, 4'b1001, "R9 set over clear");
    step(1, 0, 1, 2'b11, 2'b11, "R9 set over clear held");
    step(0, 0, 1, 2'b00, 2'b00, "R10 released at nine");
    step(1, 0, 1, 2'b00, 2'b00, "R10 nine to zero");
    step(1, 0, 1, 2'b00, 2'b00, "R10 resume");
    force_now(2'b00, 2'b11, 4'b1001, "R8 set unchained");
    step(0, 0, 0, 2'b00, 2'b00, "R10 unchained release");
    step(0, 1, 0, 2'b00, 2'b00, "R10 high wraps from four");

    repeat (3) @(negedge clk_i);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule